// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller collects up to 32 interrupt request lines from peripherals and drives a single request toward a processor. Each line latches into a status bit. An enable mask selects which latched bits count as pending. A two-bit master control gates the processor request and the capture of hardware inputs. A vector word names the lowest-numbered pending line, so the service routine can branch without scanning a mask.

Software reaches the controller through eight 32-bit words, selected by a 3-bit word index (byte offset = 4 × index). The word order is:

| Index | Word |
|---|---|
| 0 | status |
| 1 | pending |
| 2 | enable |
| 3 | acknowledge |
| 4 | set-enable |
| 5 | clear-enable |
| 6 | vector |
| 7 | master |

Reads are combinational from the selected word. A write takes effect at the rising clock edge on which `bus_wr` is high. Each line is sensed either as a level or as a rising edge. The sense is fixed by a per-line build parameter, `EDGE_LINES`, where bit n = 1 makes line n edge-sensed. By default, lines 0 to 15 are level-sensed and lines 16 to 31 are edge-sensed.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status, enable and master words read 0, the vector word reads 0xFFFFFFFF and `irq_out` is low.
- R2: A level-sensed line that is high at a rising edge sets its status bit (bit n for line n) at that edge, but only while master bit 1 is set; with master bit 1 clear, no input sets a status bit.
- R3: An edge-sensed line sets its status bit only at an edge where it is high and was low at the previous edge. Holding it high or dropping it sets nothing.
- R4: Writing to the acknowledge word (index 3) clears each status bit whose write bit is 1. A level-sensed line still held high is latched again.
- R5: When a capture and an acknowledge of the same status bit fall on the same edge, the bit ends set.
- R6: Writing the enable word (index 2) replaces all enable bits with the write data.
- R7: Writing the set-enable word (index 4) sets the enable bits whose write bit is 1. Writing the clear-enable word (index 5) clears them. Other enable bits keep their value.
- R8: The pending word (index 1) reads as status AND enable.
- R9: `irq_out` is high exactly when pending is nonzero and master bit 0 is set.
- R10: The vector word (index 6) reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when nothing is pending.
- R11: Writes to the status, pending and vector words change nothing. The acknowledge, set-enable and clear-enable words read as 0.
- R12: The master word (index 7) keeps write bits [1:0] and reads back with bits [31:2] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, line n on bit n |
| bus_word | input | 3 | Word index for both read and write |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Every register effect of a write or an input change is visible one rising edge after the stimulus. The read path and `irq_out` add no further delay, because they are combinational from the registers.

The bench applies each stimulus at a falling edge and lets one rising edge pass. It then moves `bus_word` to the word under test and samples a few nanoseconds later, well before the next edge.

Edge-sensed lines compare the current input with the value held from the previous edge. For that reason, each table row keeps its input pattern for exactly one clock, and the expected status follows from the previous row's input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 3;

  typedef enum logic [WORD_W-1:0] {
    W_STAT = 3'd0,
    W_PEND = 3'd1,
    W_ENAB = 3'd2,
    W_ACK  = 3'd3,
    W_SETE = 3'd4,
    W_CLRE = 3'd5,
    W_VECT = 3'd6,
    W_MAST = 3'd7
  } reg_word_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_LINES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] ack_mask,
  output logic [N_SRC-1:0] status_q
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    if (EDGE_LINES[g]) begin : g_edge
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= irq_in[g];
      end
      assign hit[g] = hw_en & irq_in[g] & ~last_q;
    end else begin : g_level
      assign hit[g] = hw_en & irq_in[g];
    end
  end

  // new captures override a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~ack_mask) | hit;
  end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  enable_q,
  output logic [1:0]        master_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      master_q <= '0;
    end else if (wr) begin
      case (word)
        W_ENAB:  enable_q <= wdata;
        W_SETE:  enable_q <= enable_q | wdata;
        W_CLRE:  enable_q <= enable_q & ~wdata;
        W_MAST:  master_q <= wdata[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_LINES = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]  status_q, enable_q, pend, ack_mask;
  logic [1:0]        master_q;
  logic              any_pend;
  logic [IDX_W-1:0]  low_idx;
  logic [DATA_W-1:0] vec_word;

  assign ack_mask = (bus_wr && bus_word == W_ACK) ? bus_wdata[N_SRC-1:0] : '0;

  irqc_capture #(.N_SRC(N_SRC), .EDGE_LINES(EDGE_LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .hw_en(master_q[1]), .irq_in(irq_in),
    .ack_mask(ack_mask), .status_q(status_q)
  );

  irqc_ctrl_regs #(.N_SRC(N_SRC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .word(bus_word),
    .wdata(bus_wdata[N_SRC-1:0]), .enable_q(enable_q), .master_q(master_q)
  );

  assign pend = status_q & enable_q;

  irqc_prio #(.N_SRC(N_SRC)) u_prio (.pend(pend), .any(any_pend), .idx(low_idx));

  assign vec_word = any_pend ? DATA_W'(low_idx) : '1;
  assign irq_out  = any_pend & master_q[0];

  always_comb begin
    case (bus_word)
      W_STAT:  bus_rdata = DATA_W'(status_q);
      W_PEND:  bus_rdata = DATA_W'(pend);
      W_ENAB:  bus_rdata = DATA_W'(enable_q);
      W_VECT:  bus_rdata = vec_word;
      W_MAST:  bus_rdata = DATA_W'(master_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_word,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_out,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic [1:0]        master_q,
  input logic [DATA_W-1:0] vec_word
);
  logic [N_SRC-1:0] pend_c;
  logic [N_SRC-1:0] below;
  assign pend_c = status_q & enable_q;
  assign below  = (N_SRC'(1) << vec_word[IDX_W-1:0]) - N_SRC'(1);

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[1] |=> ((status_q & ~$past(status_q)) == '0));

  // R7
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_SETE) |=>
      ((enable_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  // R7
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_CLRE) |=> ((enable_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  // R9
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_q[0] |-> !irq_out);

  // R10
  vec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_c == '0) |-> (vec_word == '1));

  // R10
  vec_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_c != '0) |-> (pend_c[vec_word[IDX_W-1:0]] && ((pend_c & below) == '0)));

  // R11
  ro_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word == W_STAT && !master_q[1]) |=> (status_q == $past(status_q)));
endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .status_q(status_q),
  .enable_q(enable_q), .master_q(master_q), .vec_word(vec_word)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [2:0]  bus_word = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_word(bus_word),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // row: tag[127:104] irq[103:72] wr[71] wword[70:68] wdata[67:36] rword[35:33] exp[32:1] exp_irq[0]
  localparam int ROWS = 22;
  localparam logic [127:0] TBL [ROWS] = '{
    {" R12", 32'h0,       1'b1, 3'd7, 32'h3,        3'd7, 32'h3,        1'b0}, // R12
    {"  R6", 32'h0,       1'b1, 3'd2, 32'h5,        3'd2, 32'h5,        1'b0}, // R6
    {"  R2", 32'h4,       1'b0, 3'd0, 32'h0,        3'd0, 32'h4,        1'b1}, // R2
    {" R10", 32'h4,       1'b0, 3'd0, 32'h0,        3'd6, 32'h2,        1'b1}, // R10
    {"  R8", 32'h6,       1'b0, 3'd0, 32'h0,        3'd1, 32'h4,        1'b1}, // R8
    {"  R7", 32'h6,       1'b1, 3'd4, 32'h2,        3'd6, 32'h1,        1'b1}, // R7
    {"  R7", 32'h0,       1'b1, 3'd5, 32'h7,        3'd2, 32'h0,        1'b0}, // R7
    {"  R4", 32'h0,       1'b1, 3'd3, 32'hFFFFFFFF, 3'd0, 32'h0,        1'b0}, // R4
    {" R10", 32'h0,       1'b0, 3'd0, 32'h0,        3'd6, 32'hFFFFFFFF, 1'b0}, // R10
    {"  R3", 32'h10000,   1'b1, 3'd2, 32'h10000,    3'd0, 32'h10000,    1'b1}, // R3
    {"  R3", 32'h10000,   1'b1, 3'd3, 32'h10000,    3'd0, 32'h0,        1'b0}, // R3
    {"  R3", 32'h0,       1'b0, 3'd0, 32'h0,        3'd0, 32'h0,        1'b0}, // R3
    {"  R5", 32'h10000,   1'b1, 3'd3, 32'h10000,    3'd0, 32'h10000,    1'b1}, // R5
    {" R11", 32'h10000,   1'b1, 3'd0, 32'h0,        3'd0, 32'h10000,    1'b1}, // R11
    {" R11", 32'h10000,   1'b1, 3'd6, 32'h5,        3'd6, 32'h10,       1'b1}, // R11
    {"  R9", 32'h10000,   1'b1, 3'd7, 32'h2,        3'd7, 32'h2,        1'b0}, // R9
    {" R12", 32'h10000,   1'b1, 3'd7, 32'hFFFFFFFD, 3'd7, 32'h1,        1'b1}, // R12
    {"  R2", 32'h1,       1'b1, 3'd2, 32'h10001,    3'd0, 32'h10000,    1'b1}, // R2
    {" R11", 32'h1,       1'b0, 3'd0, 32'h0,        3'd3, 32'h0,        1'b1}, // R11
    {" R12", 32'h1,       1'b1, 3'd7, 32'h3,        3'd7, 32'h3,        1'b1}, // R12
    {"  R2", 32'h1,       1'b0, 3'd0, 32'h0,        3'd0, 32'h10001,    1'b1}, // R2
    {"  R4", 32'h1,       1'b1, 3'd3, 32'h10001,    3'd0, 32'h1,        1'b1}  // R4
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_word(input logic [2:0] w, input string req, input logic [31:0] exp);
    bus_word = w;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_word(3'd0, "R1 status", 32'h0);
    read_word(3'd2, "R1 enable", 32'h0);
    read_word(3'd7, "R1 master", 32'h0);
    read_word(3'd6, "R1 vector", 32'hFFFFFFFF);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      irq_in    = TBL[r][103:72];
      bus_wr    = TBL[r][71];
      bus_word  = TBL[r][70:68];
      bus_wdata = TBL[r][67:36];
      @(posedge clk);
      #5;
      bus_wr = 1'b0;
      read_word(TBL[r][35:33], string'(TBL[r][127:104]), TBL[r][32:1]);
      check({string'(TBL[r][127:104]), " R9 irq_out"}, {31'b0, irq_out}, {31'b0, TBL[r][0]});
    end

    // R1: reset in the middle of a run clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(3'd0, "R1 status after reset", 32'h0);
    read_word(3'd2, "R1 enable after reset", 32'h0);
    read_word(3'd7, "R1 master after reset", 32'h0);
    read_word(3'd6, "R1 vector after reset", 32'hFFFFFFFF);
    check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);

    finish_run();
  end
endmodule